// File: doc/BRIEF.md
# Parallel Converter Read Sequencer

This block runs the host side of a parallel-output sampling converter. It drives chip select, convert-start and read, watches the converter's BUSY status line, and captures 16-bit conversion results. A single start request from the local logic produces one full cycle. Chip select goes low first. A short convert-start low pulse follows. The sequencer then waits for BUSY to rise, which marks the end of the conversion. It then holds read low for the data access time, latches the bus, and releases read.

The converter's BUSY line is asynchronous, so it passes through a synchronizer with a rising-edge detector. The read is gated on that edge and not on a fixed delay. Every timing value is a parameter in clock cycles, and the defaults suit a 125 MHz clock. If BUSY never returns high, a timeout ends the cycle with an error pulse. After every cycle there is an enforced quiet gap. That gap covers both the converter's minimum spacing between conversions and the time its bus needs to float. While a cycle is running, the requester sees a busy flag and any new start request is dropped.

Top module: `adc_rd_ctrl`

## Requirements
- R1: After reset, `cs_n`, `cnv_n` and `rd_n` are high, and `data_vld`, `err_timeout` and `busy_o` are low.
- R2: Once a start request is accepted, `cs_n` goes low, and `cnv_n` falls exactly CS_SETUP_CYC cycles later (default 2). `cnv_n` never falls while `cs_n` is high in the preceding cycle.
- R3: `cnv_n` stays low for exactly CNV_LOW_CYC cycles (default 6) and then returns high for the rest of the cycle.
- R4: `rd_n` falls exactly SYNC_STAGES clock edges (default 2) after the first edge that samples `adc_busy` high following the conversion. `rd_n` never falls while `adc_busy` is low.
- R5: `rd_n` stays low for exactly ACCESS_CYC cycles (default 8). The bus word is captured at the last edge of that window. `data_vld` is a one-cycle pulse in the cycle where `rd_n` returns high, and `data_out` then carries the captured word with bit 15 as the MSB.
- R6: After a cycle ends, `cs_n`, `cnv_n` and `rd_n` remain high for max(GAP_CYC, FLOAT_CYC) cycles (default 26) before a new start is accepted. As a result, at least 25 cycles (200 ns) pass between BUSY rising and the next `cnv_n` fall.
- R7: `busy_o` is high from the cycle after an accepted start until the gap ends. A `start` that arrives while `busy_o` is high starts no conversion and produces no result.
- R8: If no BUSY rising edge is seen within TIMEOUT_CYC cycles (default 600) of `cnv_n` rising, `err_timeout` pulses for one cycle exactly TIMEOUT_CYC cycles after that rise. In that case `rd_n` never falls, no `data_vld` follows, and the block returns to idle through the gap.
- R9: `rd_n` is low only while `cs_n` is low and `cnv_n` is high.
- R10: When all three strobes are idle (`busy_o` low), `cs_n`, `cnv_n` and `rd_n` are all high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request one conversion-and-read cycle |
| adc_busy | input | 1 | Converter status, low while converting (asynchronous) |
| adc_data | input | 16 | Converter parallel data bus |
| cs_n | output | 1 | Converter chip select, active low |
| cnv_n | output | 1 | Convert-start, conversion begins on its falling edge |
| rd_n | output | 1 | Read enable, active low |
| data_out | output | 16 | Last captured result |
| data_vld | output | 1 | One-cycle strobe for a new result on data_out |
| busy_o | output | 1 | A cycle is in progress; start is ignored |
| err_timeout | output | 1 | One-cycle pulse when BUSY never returned high |

## Verification
The bench counts positive edges and times every output change against a fixed schedule. `cnv_n` falls 2 cycles after `cs_n`, and rises 6 cycles later. `rd_n` falls 2 edges after the converter model first presents BUSY high, and rises 8 cycles after that, with `data_vld` in the same cycle. A timeout error lands exactly 600 cycles after `cnv_n` rises. Outputs are sampled on the falling clock edge, so each measured difference is an exact cycle count. The converter model drives the valid word onto the bus only once read has been low for 60 ns, so a window that is too short captures filler data. The gap check compares the BUSY rise to the next convert start against 25 cycles, a value taken from the 200 ns spacing rather than from a parameter.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_PULSE,
    ST_WAIT,
    ST_READ,
    ST_GAP
  } ctl_state_e;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/adc_rd_edge_sync.sv
module adc_rd_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic rise_o
);

  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q[0] <= 1'b1;
    else        chain_q[0] <= async_i;
  end

  // each further stage resamples the one before it
  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[g] <= 1'b1;
      else        chain_q[g] <= chain_q[g-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= chain_q[STAGES-1];
  end

  assign rise_o = chain_q[STAGES-1] & ~prev_q;

endmodule

// File: rtl/adc_rd_timer.sv
module adc_rd_timer #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)              cnt_d = load_val;
    else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/adc_rd_ctrl.sv
module adc_rd_ctrl
  import adc_rd_pkg::*;
#(
  parameter int DATA_W       = 16,
  parameter int SYNC_STAGES  = 2,
  parameter int CS_SETUP_CYC = 2,
  parameter int CNV_LOW_CYC  = 6,
  parameter int ACCESS_CYC   = 8,
  parameter int FLOAT_CYC    = 10,
  parameter int GAP_CYC      = 26,
  parameter int TIMEOUT_CYC  = 600
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              adc_busy,
  input  logic [DATA_W-1:0] adc_data,
  output logic              cs_n,
  output logic              cnv_n,
  output logic              rd_n,
  output logic [DATA_W-1:0] data_out,
  output logic              data_vld,
  output logic              busy_o,
  output logic              err_timeout
);

  localparam int GAP_LEN  = max2(GAP_CYC, FLOAT_CYC);
  localparam int SHORTEST = max2(max2(CS_SETUP_CYC, CNV_LOW_CYC), ACCESS_CYC);
  localparam int LONGEST  = max2(max2(TIMEOUT_CYC, GAP_LEN), SHORTEST);
  localparam int TMR_W    = $clog2(LONGEST) + 1;

  localparam logic [TMR_W-1:0] LD_SETUP = TMR_W'(CS_SETUP_CYC - 1);
  localparam logic [TMR_W-1:0] LD_PULSE = TMR_W'(CNV_LOW_CYC - 1);
  localparam logic [TMR_W-1:0] LD_WAIT  = TMR_W'(TIMEOUT_CYC - 1);
  localparam logic [TMR_W-1:0] LD_READ  = TMR_W'(ACCESS_CYC - 1);
  localparam logic [TMR_W-1:0] LD_GAP   = TMR_W'(GAP_LEN - 1);

  ctl_state_e st_q, st_d;
  logic              tmr_load, tmr_zero;
  logic [TMR_W-1:0]  tmr_val;
  logic              busy_rise;
  logic              cap_en, err_d;
  logic              cs_n_q, cnv_n_q, rd_n_q, vld_q, busy_q, err_q;
  logic [DATA_W-1:0] word_q;

  adc_rd_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (adc_busy),
    .rise_o  (busy_rise)
  );

  adc_rd_timer #(.W(TMR_W)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  // next-state logic
  always_comb begin
    st_d     = st_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    cap_en   = 1'b0;
    err_d    = 1'b0;
    unique case (st_q)
      ST_IDLE: if (start) begin
        st_d = ST_SETUP; tmr_load = 1'b1; tmr_val = LD_SETUP;
      end
      ST_SETUP: if (tmr_zero) begin
        st_d = ST_PULSE; tmr_load = 1'b1; tmr_val = LD_PULSE;
      end
      ST_PULSE: if (tmr_zero) begin
        st_d = ST_WAIT; tmr_load = 1'b1; tmr_val = LD_WAIT;
      end
      ST_WAIT: begin
        if (busy_rise) begin
          st_d = ST_READ; tmr_load = 1'b1; tmr_val = LD_READ;
        end else if (tmr_zero) begin
          st_d = ST_GAP; tmr_load = 1'b1; tmr_val = LD_GAP; err_d = 1'b1;
        end
      end
      ST_READ: if (tmr_zero) begin
        st_d = ST_GAP; tmr_load = 1'b1; tmr_val = LD_GAP; cap_en = 1'b1;
      end
      ST_GAP: if (tmr_zero) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  // state and registered pin drivers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      cs_n_q  <= 1'b1;
      cnv_n_q <= 1'b1;
      rd_n_q  <= 1'b1;
      vld_q   <= 1'b0;
      busy_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      cs_n_q  <= !(st_d inside {ST_SETUP, ST_PULSE, ST_WAIT, ST_READ});
      cnv_n_q <= (st_d != ST_PULSE);
      rd_n_q  <= (st_d != ST_READ);
      vld_q   <= cap_en;
      busy_q  <= (st_d != ST_IDLE);
      err_q   <= err_d;
    end
  end

  // result register, enabled only at the end of the read window
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      word_q <= '0;
    else if (cap_en) word_q <= adc_data;
  end

  assign cs_n        = cs_n_q;
  assign cnv_n       = cnv_n_q;
  assign rd_n        = rd_n_q;
  assign data_out    = word_q;
  assign data_vld    = vld_q;
  assign busy_o      = busy_q;
  assign err_timeout = err_q;

endmodule

// File: rtl/adc_rd_ctrl_chk.sv
module adc_rd_ctrl_chk #(
  parameter int CNV_LOW_CYC = 6
) (
  input logic clk,
  input logic rst_n,
  input logic adc_busy,
  input logic cs_n,
  input logic cnv_n,
  input logic rd_n,
  input logic data_vld,
  input logic busy_o,
  input logic err_timeout
);

  logic [15:0] lo_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lo_cnt <= '0;
    else if (!cnv_n) lo_cnt <= (lo_cnt == 16'hFFFF) ? lo_cnt : lo_cnt + 16'd1;
    else             lo_cnt <= '0;
  end

  // R2
  cs_before_cnv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cnv_n) |-> $past(!cs_n));

  // R3
  cnv_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cnv_n) |-> (lo_cnt == 16'(CNV_LOW_CYC)));

  // R4
  rd_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_n) |-> adc_busy);

  // R5
  vld_on_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_vld |-> $rose(rd_n));

  // R8
  err_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_timeout |-> (rd_n && !data_vld));

  // R9
  rd_gating_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> (!cs_n && cnv_n));

  // R10
  idle_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (cs_n && cnv_n && rd_n));

endmodule

bind adc_rd_ctrl adc_rd_ctrl_chk #(.CNV_LOW_CYC(CNV_LOW_CYC)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .adc_busy    (adc_busy),
  .cs_n        (cs_n),
  .cnv_n       (cnv_n),
  .rd_n        (rd_n),
  .data_vld    (data_vld),
  .busy_o      (busy_o),
  .err_timeout (err_timeout)
);

// File: tb/adc_rd_ctrl_tb.sv
module adc_rd_ctrl_tb;

  localparam int CONV_CYC  = 40;
  localparam int TOUT      = 600;
  localparam int MIN_SPACE = 25;

  logic        clk, rst_n, start, adc_busy;
  logic [15:0] adc_data;
  logic        cs_n, cnv_n, rd_n, data_vld, busy_o, err_timeout;
  logic [15:0] data_out;

  int n_chk, n_err;
  int cyc;
  logic [15:0] exp_q[$];
  logic [15:0] model_word;
  logic        model_en;
  int conv_left, rd_lo, t_busy, n_cnv, n_vld, n_errp;

  adc_rd_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .adc_busy(adc_busy),
    .adc_data(adc_data), .cs_n(cs_n), .cnv_n(cnv_n), .rd_n(rd_n),
    .data_out(data_out), .data_vld(data_vld), .busy_o(busy_o),
    .err_timeout(err_timeout)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // converter model: BUSY low while converting, word on bus 60 ns into read
  logic prev_cnv_m;
  always @(negedge clk) begin
    prev_cnv_m <= cnv_n;
    if (prev_cnv_m && !cnv_n && !cs_n && model_en && conv_left == 0) begin
      adc_busy  <= 1'b0;
      conv_left <= CONV_CYC;
    end else if (conv_left > 0) begin
      conv_left <= conv_left - 1;
      if (conv_left == 1) begin
        adc_busy <= 1'b1;
        t_busy   <= cyc + 1;
      end
    end
    rd_lo    <= (!rd_n && !cs_n) ? rd_lo + 1 : 0;
    adc_data <= (!rd_n && !cs_n && rd_lo + 1 >= 8) ? model_word : 16'h5A5A ^ 16'(cyc);
  end

  // monitor and scoreboard
  logic p_cs, p_cnv, p_rd;
  int t_cs, t_cnv, t_cnvr, t_rd, t_last_busy;
  bit have_busy;
  always @(negedge clk) begin
    if (rst_n) begin
      if (p_cs && !cs_n) t_cs = cyc;
      if (p_cnv && !cnv_n) begin
        n_cnv++;
        // R2
        check(cyc - t_cs == 2, "R2 cs-to-convert cycles", cyc - t_cs, 2);
        // R6
        if (have_busy)
          check(cyc - t_last_busy >= MIN_SPACE, "R6 busy-rise to next convert",
                cyc - t_last_busy, MIN_SPACE);
        t_cnv = cyc;
      end
      if (!p_cnv && cnv_n) begin
        // R3
        check(cyc - t_cnv == 6, "R3 convert low width", cyc - t_cnv, 6);
        t_cnvr = cyc;
      end
      if (p_rd && !rd_n) begin
        // R4
        check(cyc - t_busy == 2, "R4 busy-to-read edges", cyc - t_busy, 2);
        t_rd = cyc; t_last_busy = t_busy; have_busy = 1'b1;
      end
      if (!p_rd && rd_n)
        check(cyc - t_rd == 8, "R5 read low width", cyc - t_rd, 8);
      if (data_vld) begin
        n_vld++;
        check(!p_rd && rd_n, "R5 valid with read release", int'(rd_n), 1);
        if (exp_q.size() == 0) check(1'b0, "R7 unexpected result", n_vld, 0);
        else begin
          automatic logic [15:0] e = exp_q.pop_front();
          check(data_out == e, "R5 captured word", int'(data_out), int'(e));
        end
      end
      if (err_timeout) begin
        n_errp++;
        // R8
        check(cyc - t_cnvr == TOUT, "R8 timeout cycle", cyc - t_cnvr, TOUT);
      end
    end
    p_cs = cs_n; p_cnv = cnv_n; p_rd = rd_n;
  end

  task automatic run_cycle(input logic [15:0] w, input bit respond, input bit poke);
    while (busy_o) @(negedge clk);
    model_en   = respond;
    model_word = w;
    if (respond) exp_q.push_back(w);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // R7
    check(busy_o == 1'b1, "R7 busy after start", int'(busy_o), 1);
    if (poke) begin
      repeat (12) @(negedge clk);
      start = 1'b1; @(negedge clk); start = 1'b0;
      while (rd_n) @(negedge clk);
      start = 1'b1; @(negedge clk); start = 1'b0;
      while (!rd_n) @(negedge clk);
      repeat (3) @(negedge clk);
      start = 1'b1; @(negedge clk); start = 1'b0;
    end
    while (busy_o) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic report;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
    report();
    $finish;
  end

  initial begin
    n_chk = 0; n_err = 0; cyc = 0; start = 1'b0; adc_busy = 1'b1;
    adc_data = '0; model_en = 1'b1; model_word = '0; conv_left = 0;
    rd_lo = 0; t_busy = 0; n_cnv = 0; n_vld = 0; n_errp = 0;
    prev_cnv_m = 1'b1; p_cs = 1'b1; p_cnv = 1'b1; p_rd = 1'b1;
    t_cs = 0; t_cnv = 0; t_cnvr = 0; t_rd = 0; t_last_busy = 0; have_busy = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1
    check(cs_n && cnv_n && rd_n, "R1 strobes high in reset", int'({cs_n, cnv_n, rd_n}), 7);
    check(!data_vld && !busy_o && !err_timeout, "R1 flags low in reset",
          int'({data_vld, busy_o, err_timeout}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(cs_n && cnv_n && rd_n && !busy_o, "R1 idle after reset",
          int'({cs_n, cnv_n, rd_n, busy_o}), 14);

    run_cycle(16'h0000, 1'b1, 1'b0);
    run_cycle(16'hFFFF, 1'b1, 1'b0);
    run_cycle(16'h8000, 1'b1, 1'b1);
    // R7: the three extra requests must not start conversions
    check(n_cnv == 3, "R7 ignored starts", n_cnv, 3);
    run_cycle(16'h7FFF, 1'b1, 1'b0);
    run_cycle(16'hA5C3, 1'b1, 1'b0);

    // R8: converter never answers
    have_busy = 1'b0;
    run_cycle(16'h1234, 1'b0, 1'b0);
    check(n_errp == 1, "R8 one error pulse", n_errp, 1);
    check(n_vld == 5, "R8 no result on timeout", n_vld, 5);

    // recovery after timeout
    run_cycle(16'h0F0F, 1'b1, 1'b0);
    check(n_vld == 6, "R5 result count", n_vld, 6);
    check(exp_q.size() == 0, "R7 scoreboard drained", exp_q.size(), 0);
    check(n_cnv == 7, "R7 conversion count", n_cnv, 7);

    report();
    $finish;
  end

endmodule